// File: doc/BRIEF.md
# Serial Memory Command Front End

This block is the command side of a byte-addressed nonvolatile memory that a host reaches over a single-lane SPI link. It works in SPI clock modes 0 and 3 and runs on the chip's own clock. The three link inputs pass through a synchroniser, and clock edges are found by comparing samples. A command byte is shifted in MSB first and decoded. The block then either acts on it directly, streams a reply, or collects a 3-byte address and moves data through a simple byte port into a memory array. It also owns the write-enable flag and a small status byte.

The memory holds 2^ADDR_W bytes, which is 512K with the default ADDR_W = 19. Bits of the transmitted 24-bit address above ADDR_W are dropped. Reads and writes may run on without limit while chip select stays low, and the address wraps from the top byte to zero. For a read, the next byte is fetched from the array as soon as the current byte has been handed to the output shifter.

States: IDLE (chip select high), CMD (op-code shifting), ADDR (address shifting), WDATA (memory write stream), RDATA (memory read stream), STAT_RD (status reply), STAT_WR (status update), ID_RD (identity reply), SKIP (ignore the rest of the frame). Transitions:
- IDLE to CMD when chip select goes low.
- CMD to ADDR, STAT_RD, STAT_WR, ID_RD or SKIP on the 8th op-code bit.
- ADDR to WDATA or RDATA on the last address bit.
- STAT_WR to SKIP after its first data byte.
- Any state to IDLE when chip select goes high.

Top module: `serial_mem_front`

## Requirements
- R1: Op-codes are decoded as follows: 0x06 sets the write-enable flag, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads memory, 0x02 writes memory, 0x9F reads the identity. Any other op-code is a no-op: `spi_miso_oe` stays low and no memory strobe is issued until chip select rises.
- R2: If chip select rises before the 8th op-code bit, nothing is executed and the write-enable flag is unchanged.
- R3: Op-code 0x06 sets the write-enable flag and 0x04 clears it. Both take effect on the 8th op-code bit.
- R4: The status reply is {sr[7:2], wel, 1'b0}, sent MSB first. It repeats every 8 clocks while chip select stays low.
- R5: A status write (0x01) with the write-enable flag set loads sr[7:2] from bits 7:2 of the first data byte and ignores the rest. With the flag clear, the status write has no effect.
- R6: A memory write (0x02) with the flag set takes a 3-byte address MSB first, of which only the low ADDR_W bits are kept. Each complete data byte (D7 first) produces one `mem_wr_en` pulse at the current address, and the address then increments. A partial final byte is discarded.
- R7: A memory write issued while the write-enable flag is clear produces no `mem_wr_en` pulse.
- R8: The write-enable flag clears when chip select rises after an accepted memory or status write.
- R9: A memory read (0x03) takes a 3-byte address, then returns array bytes MSB first on `spi_miso`. Bits change after falling SCK edges and are valid at rising edges. The address increments on each byte for as long as clocking continues.
- R10: The address wraps from 2^ADDR_W-1 to 0 for both reads and writes.
- R11: The identity read returns the bytes of DEVICE_ID, most significant byte first, and repeats cyclically.
- R12: Mode 0 (SCK idle low) and mode 3 (SCK idle high) give identical results.
- R13: After reset, `spi_miso_oe`, `mem_rd_en` and `mem_wr_en` are low and the write-enable flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | High while a reply is being driven |
| mem_addr | output | ADDR_W | Array byte address |
| mem_rd_en | output | 1 | Array read strobe; data is expected on mem_rdata one clock later |
| mem_rdata | input | 8 | Array read data |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with the default ADDR_W = 19 and SYNC_STAGES = 2, and with ID_BYTES = 3 and DEVICE_ID = 24'hC35A19. With a 3-byte identity, wrap-around of the identity reply shows up after only four reply bytes. Keeping the full 19-bit address makes the top-address rollover reachable by sending address 0x7FFFF directly, and lets an address with the upper five bits set demonstrate that those bits are dropped. The SCK half period is 8 block clocks, which leaves room for the two synchroniser stages and the one-clock array read latency.

// File: rtl/smem_pkg.sv
package smem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT_RD,
        ST_STAT_WR,
        ST_ID_RD,
        ST_SKIP
    } smem_state_e;

    localparam logic [7:0] OP_WEL_SET  = 8'h06;
    localparam logic [7:0] OP_WEL_CLR  = 8'h04;
    localparam logic [7:0] OP_STAT_GET = 8'h05;
    localparam logic [7:0] OP_STAT_PUT = 8'h01;
    localparam logic [7:0] OP_MEM_GET  = 8'h03;
    localparam logic [7:0] OP_MEM_PUT  = 8'h02;
    localparam logic [7:0] OP_IDENT    = 8'h9F;

endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/smem_edges.sv
module smem_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_s,
    input  logic cs_n_s,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);

    logic sck_d;
    logic cs_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_n_s;
        end
    end

    assign sck_rise = sck_s & ~sck_d;
    assign sck_fall = ~sck_s & sck_d;
    assign cs_rise  = cs_n_s & ~cs_d;

endmodule

// File: rtl/serial_mem_front.sv
module serial_mem_front
    import smem_pkg::*;
#(
    parameter int                    ADDR_W      = 19,
    parameter int                    ADDR_BYTES  = 3,
    parameter int                    SYNC_STAGES = 2,
    parameter int                    ID_BYTES    = 4,
    parameter logic [8*ID_BYTES-1:0] DEVICE_ID   = 32'h7F3C91E4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [7:0]        mem_rdata,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wdata
);

    localparam int ADDR_BITS = 8 * ADDR_BYTES;
    localparam int ACNT_W    = $clog2(ADDR_BITS);
    localparam int IDX_W     = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BITS - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(ID_BYTES - 1);

    // synchronised link inputs: {sck, cs_n, mosi}
    logic [2:0] link_s;
    logic       sck_s, cs_s, mosi_s;
    logic       sck_rise, sck_fall, cs_rise;

    smem_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_cs_n, spi_mosi}),
        .q     (link_s)
    );

    assign sck_s  = link_s[2];
    assign cs_s   = link_s[1];
    assign mosi_s = link_s[0];

    smem_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_s    (sck_s),
        .cs_n_s   (cs_s),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    smem_state_e       state, state_nx;
    logic [2:0]        bit_cnt;
    logic [ACNT_W-1:0] addr_cnt;
    logic [6:0]        rx_sr;
    logic [7:0]        cur_byte;
    logic [7:0]        tx_sr;
    logic [7:0]        out_byte;
    logic [ADDR_W-1:0] addr_q;
    logic              is_write_q;
    logic              wr_cmd_q;
    logic              wel_q;
    logic [5:0]        sr_bits;
    logic [IDX_W-1:0]  id_idx;
    logic              rd_req, rd_vld;
    logic [7:0]        rd_buf;
    logic              wr_pend;
    logic [7:0]        wdata_q;
    logic              byte_done;
    logic              out_state;
    logic              load_out;

    assign cur_byte  = {rx_sr, mosi_s};
    assign byte_done = sck_rise && (bit_cnt == 3'd7) && !cs_s;
    assign out_state = (state == ST_RDATA) || (state == ST_STAT_RD) || (state == ST_ID_RD);
    assign load_out  = out_state && sck_fall && (bit_cnt == 3'd0);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        if (cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_CMD;
                ST_CMD: begin
                    if (byte_done) begin
                        case (cur_byte)
                            OP_STAT_GET: state_nx = ST_STAT_RD;
                            OP_STAT_PUT: state_nx = wel_q ? ST_STAT_WR : ST_SKIP;
                            OP_MEM_GET:  state_nx = ST_ADDR;
                            OP_MEM_PUT:  state_nx = wel_q ? ST_ADDR : ST_SKIP;
                            OP_IDENT:    state_nx = ST_ID_RD;
                            default:     state_nx = ST_SKIP;
                        endcase
                    end
                end
                ST_ADDR: begin
                    if (sck_rise && addr_cnt == ACNT_LAST)
                        state_nx = is_write_q ? ST_WDATA : ST_RDATA;
                end
                ST_STAT_WR: begin
                    if (byte_done) state_nx = ST_SKIP;
                end
                ST_WDATA, ST_RDATA, ST_STAT_RD, ST_ID_RD, ST_SKIP: state_nx = state;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- reply byte select ----------------
    always_comb begin
        unique case (state)
            ST_STAT_RD: out_byte = {sr_bits, wel_q, 1'b0};
            ST_ID_RD:   out_byte = DEVICE_ID[(ID_BYTES - 1 - int'(id_idx)) * 8 +: 8];
            ST_RDATA:   out_byte = rd_buf;
            default:    out_byte = 8'h00;
        endcase
    end

    // ---------------- outputs and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            addr_cnt   <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            addr_q     <= '0;
            is_write_q <= 1'b0;
            wr_cmd_q   <= 1'b0;
            wel_q      <= 1'b0;
            sr_bits    <= '0;
            id_idx     <= '0;
            rd_req     <= 1'b0;
            rd_vld     <= 1'b0;
            rd_buf     <= '0;
            wr_pend    <= 1'b0;
            wdata_q    <= '0;
        end else begin
            rd_req  <= 1'b0;
            wr_pend <= 1'b0;
            rd_vld  <= rd_req;
            if (rd_vld) rd_buf <= mem_rdata;

            if (state == ST_IDLE) begin
                bit_cnt    <= '0;
                addr_cnt   <= '0;
                tx_sr      <= '0;
                id_idx     <= '0;
                is_write_q <= 1'b0;
                wr_cmd_q   <= 1'b0;
            end else begin
                if (sck_rise) begin
                    bit_cnt <= bit_cnt + 3'd1;
                    rx_sr   <= cur_byte[6:0];
                end
                if (load_out) begin
                    tx_sr <= out_byte;
                end else if (sck_fall) begin
                    tx_sr <= {tx_sr[6:0], 1'b0};
                end
            end

            // op-code decode on the 8th bit
            if (state == ST_CMD && byte_done) begin
                unique case (cur_byte)
                    OP_WEL_SET: wel_q <= 1'b1;
                    OP_WEL_CLR: wel_q <= 1'b0;
                    OP_MEM_PUT: begin
                        is_write_q <= wel_q;
                        wr_cmd_q   <= wel_q;
                    end
                    OP_STAT_PUT: wr_cmd_q <= wel_q;
                    default: ;
                endcase
            end else if (cs_rise && wr_cmd_q) begin
                wel_q <= 1'b0;
            end

            // address capture, high bits fall off the register
            if (state == ST_ADDR && sck_rise) begin
                addr_q   <= {addr_q[ADDR_W-2:0], mosi_s};
                addr_cnt <= addr_cnt + ACNT_W'(1);
                if (addr_cnt == ACNT_LAST && !is_write_q) rd_req <= 1'b1;
            end else if (wr_pend) begin
                addr_q <= addr_q + ADDR_W'(1);
            end else if (state == ST_RDATA && load_out) begin
                addr_q <= addr_q + ADDR_W'(1);
                rd_req <= 1'b1;
            end

            if (state == ST_WDATA && byte_done) begin
                wr_pend <= 1'b1;
                wdata_q <= cur_byte;
            end

            if (state == ST_STAT_WR && byte_done) sr_bits <= cur_byte[7:2];

            if (state == ST_ID_RD && load_out)
                id_idx <= (id_idx == IDX_LAST) ? '0 : id_idx + IDX_W'(1);
        end
    end

    assign spi_miso    = tx_sr[7];
    assign spi_miso_oe = out_state;
    assign mem_addr    = addr_q;
    assign mem_rd_en   = rd_req;
    assign mem_wr_en   = wr_pend;
    assign mem_wdata   = wdata_q;

    // ---------------- assertions ----------------
    // R1
    skip_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |=> (state == ST_SKIP || state == ST_IDLE));

    // R2
    cut_cmd_keeps_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && cs_rise) |=> $stable(wel_q));

    // R7
    wr_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> $past(wel_q));

    // R8
    wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && wr_cmd_q) |=> !wel_q);

    // R9
    rd_only_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !is_write_q);

    // R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr_en, mem_rd_en}));

endmodule

// File: tb/serial_mem_front_tb.sv
module serial_mem_front_tb;

    localparam int ADDR_W = 19;
    localparam int H      = 8;
    localparam logic [ADDR_W-1:0] AMASK = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, mem_rd_en, mem_wr_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rdata = '0, mem_wdata;

    always #4 clk = ~clk;

    serial_mem_front #(
        .ADDR_W      (ADDR_W),
        .ADDR_BYTES  (3),
        .SYNC_STAGES (2),
        .ID_BYTES    (3),
        .DEVICE_ID   (24'hC35A19)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sck     (sck),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rdata   (mem_rdata),
        .mem_wr_en   (mem_wr_en),
        .mem_wdata   (mem_wdata)
    );

    int checks = 0;
    int bad    = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [7:0]  bmem [int];
    logic [7:0]  refm [int];
    logic [26:0] exp_wr [$];
    logic [7:0]  tx_q [$];
    logic [7:0]  rx_q [$];
    bit ref_wel = 0;
    logic [5:0] ref_sr = '0;
    bit oe_any, rd_any;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // array model and per-clock write comparison
    always @(posedge clk) begin
        if (mem_rd_en) begin
            rd_any = 1;
            mem_rdata <= bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : 8'h00;
        end
        if (mem_wr_en) begin
            bmem[int'(mem_addr)] = mem_wdata;
            if (exp_wr.size() == 0) begin
                chk("R7 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
            end else begin
                logic [26:0] e;
                e = exp_wr.pop_front();
                chk("R6 write strobe", {5'h0, mem_addr, mem_wdata}, {5'h0, e});
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send tx_q; the last byte sends only nlast bits; replies land in rx_q
    task automatic spi_run(input int nlast, input bit m3);
        logic [7:0] cap;
        rx_q.delete();
        oe_any = 0;
        rd_any = 0;
        @(negedge clk);
        sck = m3;
        waitc(H);
        cs_n = 1'b0;
        waitc(H);
        for (int i = 0; i < tx_q.size(); i++) begin
            int nb;
            nb = (i == tx_q.size() - 1) ? nlast : 8;
            cap = '0;
            for (int b = 0; b < nb; b++) begin
                sck  = 1'b0;
                mosi = tx_q[i][7 - b];
                waitc(H);
                cap = {cap[6:0], miso};
                if (miso_oe) oe_any = 1;
                sck = 1'b1;
                waitc(H);
            end
            if (nb == 8) rx_q.push_back(cap);
        end
        if (!m3) sck = 1'b0;
        waitc(H);
        cs_n = 1'b1;
        waitc(2 * H + 4);
    endtask

    task automatic op_only(input logic [7:0] op);
        tx_q = '{op};
        spi_run(8, 0);
        if (op == 8'h06) ref_wel = 1;
        if (op == 8'h04) ref_wel = 0;
    endtask

    task automatic stat_read(input string req, input bit m3);
        tx_q = '{8'h05, 8'h00, 8'h00};
        spi_run(8, m3);
        chk(req, {24'h0, rx_q[1]}, {24'h0, ref_sr, ref_wel, 1'b0});
        chk(req, {24'h0, rx_q[2]}, {24'h0, ref_sr, ref_wel, 1'b0});
    endtask

    task automatic mem_write(input logic [23:0] a, input logic [7:0] d [$], input int tail_bits);
        logic [ADDR_W-1:0] p;
        tx_q = '{8'h02, a[23:16], a[15:8], a[7:0]};
        foreach (d[k]) tx_q.push_back(d[k]);
        if (tail_bits > 0) tx_q.push_back(8'hFF);
        p = a[ADDR_W-1:0];
        if (ref_wel) begin
            foreach (d[k]) begin
                exp_wr.push_back({p, d[k]});
                refm[int'(p)] = d[k];
                p = (p + 1'b1) & AMASK;
            end
            ref_wel = 0;
        end
        spi_run(tail_bits > 0 ? tail_bits : 8, 0);
    endtask

    task automatic mem_read(input string req, input logic [23:0] a, input int n, input bit m3);
        logic [ADDR_W-1:0] p;
        tx_q = '{8'h03, a[23:16], a[15:8], a[7:0]};
        for (int k = 0; k < n; k++) tx_q.push_back(8'h00);
        spi_run(8, m3);
        p = a[ADDR_W-1:0];
        for (int k = 0; k < n; k++) begin
            chk(req, {24'h0, rx_q[4 + k]},
                {24'h0, refm.exists(int'(p)) ? refm[int'(p)] : 8'h00});
            p = (p + 1'b1) & AMASK;
        end
    endtask

    initial begin
        waitc(5);
        // R13: reset state
        chk("R13 oe", {31'h0, miso_oe}, 32'h0);
        chk("R13 wr", {31'h0, mem_wr_en}, 32'h0);
        chk("R13 rd", {31'h0, mem_rd_en}, 32'h0);
        rst_n = 1'b1;
        waitc(4);

        // R4/R13: status after reset shows flag clear
        stat_read("R4 initial status", 0);

        // R7: write with flag clear is dropped
        mem_write(24'h000010, '{8'hAA}, 0);
        mem_read("R7 dropped write", 24'h000010, 1, 0);

        // R3/R4: flag set, status readable repeatedly
        op_only(8'h06);
        stat_read("R3 R4 flag set", 0);

        // R6/R8: stream write, flag clears at end
        mem_write(24'h000010, '{8'h11, 8'h22, 8'h33}, 0);
        stat_read("R8 flag cleared", 0);

        // R9: stream read; R6/R12 upper address bits ignored, mode 3
        mem_read("R9 read", 24'h000010, 3, 0);
        mem_read("R6 R12 high addr bits mode3", 24'hF80010, 3, 1);

        // R10: wrap on write and read
        op_only(8'h06);
        mem_write(24'h07FFFF, '{8'hA5, 8'h5A}, 0);
        mem_read("R10 wrap", 24'h07FFFE, 4, 0);

        // R3: clear
        op_only(8'h06);
        op_only(8'h04);
        stat_read("R3 flag cleared", 0);

        // R2: op-code cut after 7 bits
        tx_q = '{8'h06};
        spi_run(7, 0);
        stat_read("R2 cut op-code", 0);

        // R1: unknown op-code
        tx_q = '{8'h55, 8'h03, 8'h00, 8'h00, 8'h10, 8'h00};
        spi_run(8, 0);
        chk("R1 no reply", {31'h0, oe_any}, 32'h0);
        chk("R1 no read", {31'h0, rd_any}, 32'h0);

        // R11: identity repeats
        tx_q = '{8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        spi_run(8, 0);
        chk("R11 id0", {24'h0, rx_q[1]}, 32'hC3);
        chk("R11 id1", {24'h0, rx_q[2]}, 32'h5A);
        chk("R11 id2", {24'h0, rx_q[3]}, 32'h19);
        chk("R11 id wrap", {24'h0, rx_q[4]}, 32'hC3);
        chk("R11 id wrap", {24'h0, rx_q[5]}, 32'h5A);

        // R5: status write with flag, then without
        op_only(8'h06);
        tx_q = '{8'h01, 8'hF3, 8'h0C};
        spi_run(8, 0);
        ref_sr = 6'b111100;
        ref_wel = 0;
        stat_read("R5 R8 status write", 0);
        tx_q = '{8'h01, 8'h0C};
        spi_run(8, 0);
        stat_read("R5 ignored status write", 0);

        // R6: partial trailing byte discarded
        op_only(8'h06);
        mem_write(24'h000020, '{8'h77}, 4);
        mem_read("R6 partial byte", 24'h000020, 2, 0);

        // R12: mode 3 status with flag set
        op_only(8'h06);
        stat_read("R12 mode3 status", 1);
        op_only(8'h04);

        chk("R6 all writes seen", exp_wr.size(), 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule